// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks the single reservation that a processor core takes with a load-linked access. The monitor records the block-aligned address of the load-linked access and sets a valid flag. Two kinds of cache event drop that flag. One is a write to the same block that the snoop port sees from another agent. The other is a local eviction of the block. A later store-conditional is granted only if the flag is still set and the request falls in the reserved block. The verdict comes back one cycle after the request, and the store is performed only when the verdict is a pass.

The monitor also keeps a block in exclusive hold while a test-and-set runs. The hold starts when the test-and-set begins and ends when both its read and its write are done. While the hold lasts, a snooped write to the held block is flagged as stalled. A stalled write is deferred, so it does not yet count as an observed write.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation exists, `sc_done` and `sc_pass` are 0, and a store-conditional with no earlier load-linked fails.
- R2: After a load-linked, a store-conditional to any byte of the same block (address bits above `OFF_W`) passes with `sc_pass`=1. The store is performed only when `sc_pass`=1.
- R3: A store-conditional to a different block from the reserved one fails.
- R4: An unstalled snooped write to the reserved block clears the reservation. A snooped write to any other block leaves it intact.
- R5: An eviction of the reserved block clears the reservation. An eviction of any other block leaves it intact.
- R6: Every store-conditional clears the reservation, whether it passes or fails, so a second one without a fresh load-linked fails.
- R7: A new load-linked replaces any earlier reservation, including its block address.
- R8: A snooped write or an eviction that hits the reserved block in the same cycle as a store-conditional makes that store-conditional fail. A load-linked in the same cycle as such an event leaves a valid reservation on the new block.
- R9: `sc_done` is 1 exactly in the cycle after a store-conditional request and 0 otherwise. `sc_pass` is never 1 while `sc_done` is 0.
- R10: Between `tas_start` and `tas_done`, a snooped write to the held block raises `snp_stall` in the same cycle and does not clear a reservation on that block. After `tas_done`, no stall is raised for that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_req | input | 1 | Load-linked issued at `req_addr` |
| sc_req | input | 1 | Store-conditional issued at `req_addr` |
| tas_start | input | 1 | Test-and-set begins on the block of `req_addr` |
| tas_done | input | 1 | Test-and-set read and write both completed |
| req_addr | input | ADDR_W | Processor request address |
| snp_wr | input | 1 | Snooped write or invalidation seen on the bus |
| snp_addr | input | ADDR_W | Address of the snooped write |
| evict_vld | input | 1 | Local eviction notice |
| evict_addr | input | ADDR_W | Address of the evicted block |
| snp_stall | output | 1 | Snooped write targets a block held by a test-and-set |
| sc_done | output | 1 | Store-conditional verdict valid |
| sc_pass | output | 1 | 1 = store-conditional passes, 0 = fails and store suppressed |

## Verification
A store-conditional and a snooped write to the reserved block can land in the same cycle. The bench drives both in one cycle and expects a fail, and repeats this with an eviction in place of the write. The converse collision is a load-linked that arrives with a snooped write to the same block. The bench drives that pair and expects the reservation to survive, which a following store-conditional shows by passing. A third overlap is a snoop during a test-and-set hold: the stall flag must rise in that cycle while the reservation on the block stays intact.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_req,
  input  logic              sc_req,
  input  logic              tas_start,
  input  logic              tas_done,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              snp_wr,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              evict_vld,
  input  logic [ADDR_W-1:0] evict_addr,
  output logic              snp_stall,
  output logic              sc_done,
  output logic              sc_pass
);
  localparam int BLK_W = ADDR_W - OFF_W;

  logic             rsv_vld, tas_hold;
  logic [BLK_W-1:0] rsv_blk, tas_blk;

  wire [BLK_W-1:0] req_blk   = req_addr[ADDR_W-1:OFF_W];
  wire [BLK_W-1:0] snp_blk   = snp_addr[ADDR_W-1:OFF_W];
  wire [BLK_W-1:0] evict_blk = evict_addr[ADDR_W-1:OFF_W];

  assign snp_stall = snp_wr & tas_hold & (snp_blk == tas_blk);

  wire snp_hit   = snp_wr & ~snp_stall & rsv_vld & (snp_blk == rsv_blk);
  wire evict_hit = evict_vld & rsv_vld & (evict_blk == rsv_blk);
  wire sc_ok     = sc_req & rsv_vld & (req_blk == rsv_blk) & ~snp_hit & ~evict_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsv_vld <= 1'b0;
      rsv_blk <= '0;
    end else if (ll_req) begin
      rsv_vld <= 1'b1;
      rsv_blk <= req_blk;
    end else if (sc_req | snp_hit | evict_hit) begin
      rsv_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tas_hold <= 1'b0;
      tas_blk  <= '0;
    end else if (tas_start) begin
      tas_hold <= 1'b1;
      tas_blk  <= req_blk;
    end else if (tas_done) begin
      tas_hold <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_done <= 1'b0;
      sc_pass <= 1'b0;
    end else begin
      sc_done <= sc_req;
      sc_pass <= sc_ok;
    end
  end

  // R6
  sc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !ll_req) |=> !rsv_vld);
  // R9
  sc_resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |=> sc_done);
  // R9
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_req |=> !sc_done);
  // R9
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass |-> sc_done);
  // R4
  snoop_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && !ll_req) |=> !rsv_vld);
  // R5
  evict_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_hit && !ll_req) |=> !rsv_vld);
  // R10
  stall_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_stall |-> (tas_hold && snp_wr));
  // R7
  ll_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ll_req |=> (rsv_vld && rsv_blk == $past(req_blk)));
endmodule

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ll_req = 0, sc_req = 0, tas_start = 0, tas_done = 0, snp_wr = 0, evict_vld = 0;
  logic [ADDR_W-1:0] req_addr = '0, snp_addr = '0, evict_addr = '0;
  logic snp_stall, sc_done, sc_pass;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_monitor #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) dut (
    .clk(clk), .rst_n(rst_n), .ll_req(ll_req), .sc_req(sc_req),
    .tas_start(tas_start), .tas_done(tas_done), .req_addr(req_addr),
    .snp_wr(snp_wr), .snp_addr(snp_addr), .evict_vld(evict_vld),
    .evict_addr(evict_addr), .snp_stall(snp_stall), .sc_done(sc_done),
    .sc_pass(sc_pass));

  localparam logic [ADDR_W-1:0] A  = 32'h0000_1000;
  localparam logic [ADDR_W-1:0] A2 = 32'h0000_103C;
  localparam logic [ADDR_W-1:0] B  = 32'h0000_2040;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    ll_req = 0; sc_req = 0; tas_start = 0; tas_done = 0; snp_wr = 0; evict_vld = 0;
  endtask

  task automatic do_ll(input logic [ADDR_W-1:0] a);
    ll_req = 1; req_addr = a; step(); idle();
  endtask

  task automatic do_sc(input logic [ADDR_W-1:0] a, input logic exp, input string req);
    sc_req = 1; req_addr = a; step(); idle();
    check(req, sc_done, 1'b1);
    check(req, sc_pass, exp);
    step();
    check("R9", sc_done, 1'b0);
    check("R9", sc_pass, 1'b0);
  endtask

  task automatic t_reset();
    check("R1", sc_done, 1'b0);
    check("R1", sc_pass, 1'b0);
    check("R1", snp_stall, 1'b0);
    do_sc(A, 1'b0, "R1");
  endtask

  task automatic t_basic();
    do_ll(A); do_sc(A2, 1'b1, "R2");
    do_ll(A); do_sc(B, 1'b0, "R3");
  endtask

  task automatic t_snoop();
    do_ll(A); snp_wr = 1; snp_addr = B; step(); idle(); do_sc(A, 1'b1, "R4 other block");
    do_ll(A); snp_wr = 1; snp_addr = A2; step(); idle(); do_sc(A, 1'b0, "R4 same block");
  endtask

  task automatic t_evict();
    do_ll(A); evict_vld = 1; evict_addr = B; step(); idle(); do_sc(A, 1'b1, "R5 other block");
    do_ll(A); evict_vld = 1; evict_addr = A; step(); idle(); do_sc(A, 1'b0, "R5 same block");
  endtask

  task automatic t_sc_clears();
    do_ll(A); do_sc(A, 1'b1, "R6 first"); do_sc(A, 1'b0, "R6 second");
    do_ll(A); do_sc(B, 1'b0, "R6 fail"); do_sc(A, 1'b0, "R6 after fail");
  endtask

  task automatic t_replace();
    do_ll(A); do_ll(B); do_sc(A, 1'b0, "R7 old");
    do_ll(A); do_ll(B); do_sc(B, 1'b1, "R7 new");
  endtask

  task automatic t_collide();
    do_ll(A);
    sc_req = 1; req_addr = A; snp_wr = 1; snp_addr = A; step(); idle();
    check("R8 sc+snoop", sc_done, 1'b1);
    check("R8 sc+snoop", sc_pass, 1'b0);
    step();
    do_ll(A);
    sc_req = 1; req_addr = A; evict_vld = 1; evict_addr = A; step(); idle();
    check("R8 sc+evict", sc_pass, 1'b0);
    step();
    ll_req = 1; req_addr = B; snp_wr = 1; snp_addr = B; step(); idle();
    do_sc(B, 1'b1, "R8 ll+snoop");
  endtask

  task automatic t_tas();
    do_ll(A);
    tas_start = 1; req_addr = A; step(); idle();
    snp_wr = 1; snp_addr = A2; #1;
    check("R10 stall", snp_stall, 1'b1);
    step(); idle();
    snp_wr = 1; snp_addr = B; #1;
    check("R10 other", snp_stall, 1'b0);
    step(); idle();
    tas_done = 1; step(); idle();
    snp_wr = 1; snp_addr = A; #1;
    check("R10 released", snp_stall, 1'b0);
    snp_wr = 0; #1;
    do_sc(A, 1'b1, "R10 kept");
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    t_reset();
    t_basic();
    t_snoop();
    t_evict();
    t_sc_clears();
    t_replace();
    t_collide();
    t_tas();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule